// File: doc/BRIEF.md
# Single-Line Debug Bit Deserializer

This block sits behind a two-pin debug adapter and turns the shared data line into the three ordinary JTAG bit streams. It samples the data line on each rising edge of the two-pin test clock, after first bringing both pins into the system clock domain. In the serial-scan mode, each frame of three test-clock edges carries, in order, an inverted TDI bit, a TMS bit and a TDO bit. At the end of each frame the block presents the recovered TDI, TMS and TDO bits together with a one-cycle strobe. That strobe stands in for one JTAG clock edge for a TAP monitor further down the chain.

The mode comes from the adapter's escape and activation logic, which sits outside this block. When the serial-scan mode is entered, the frame rotation starts at the TMS slot, so the first edge after entry is read as TMS. In four-wire mode every test-clock edge is passed through as its own strobe, with TMS taken straight from the line and the TDI and TDO bits flagged invalid. If a test-clock edge arrives in the same system cycle as mode entry, it is dropped.

Top module: `oscan1_deser`

## Requirements
- R1: While reset is held and right after it is released, `jtag_stb_o`, `tdi_o`, `tms_o`, `tdo_o` and `bits_ok_o` are all 0.
- R2: With `scan_mode_i` low, each rising edge of `tckc_i` produces exactly one strobe. At that strobe `tms_o` equals the line value, `tdi_o` and `tdo_o` are 0, and `bits_ok_o` is 0.
- R3: Every strobe lasts exactly one system clock cycle. It is visible after SYNC_STAGES+1 rising clock edges, counted from the first clock edge that samples `tckc_i` high.
- R4: In serial-scan mode, the first slot of a frame (slot code 0) stores the inverse of the line, and that value is reported on `tdi_o` at the end of the frame.
- R5: In serial-scan mode, the second slot (slot code 1) stores the line value, which is reported on `tms_o` at the end of the frame.
- R6: The third slot (slot code 2) reports the line on `tdo_o`, raises the strobe with `bits_ok_o` = 1, and returns to slot 0. The slot-0 and slot-1 edges raise no strobe and leave all outputs unchanged.
- R7: When `scan_mode_i` goes from 0 to 1, the slot is set to 1, so the first edge is read as TMS. The first frame after entry reports `tdi_o` = 0.
- R8: When `scan_mode_i` goes low, the slot returns to 0 on the next clock and any partial frame is discarded. The next edge gives a four-wire strobe, and a later re-entry starts again at the TMS slot.
- R9: The slot never holds the unused code 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tckc_i | input | 1 | Two-pin test clock, asynchronous |
| tmsc_i | input | 1 | Two-pin data line, asynchronous |
| scan_mode_i | input | 1 | 1 = serial-scan framing, 0 = four-wire pass-through |
| jtag_stb_o | output | 1 | One-cycle equivalent JTAG clock strobe |
| tdi_o | output | 1 | Recovered TDI bit |
| tms_o | output | 1 | Recovered TMS bit |
| tdo_o | output | 1 | Recovered TDO bit |
| bits_ok_o | output | 1 | TDI and TDO bits are valid for this strobe |

## Verification
The hardest case to reach is a mode change in the middle of a frame. A TMS edge seen after entry has to go into the right slot, and a frame cut short by a return to four-wire mode must not leak into the next strobe. The directed part of the bench covers these cases: it enters the mode with no frame open, abandons a half-built frame, and re-enters. The random part then toggles the mode at arbitrary points of the rotation while a bench-side slot model predicts every strobe and every silent edge.

// File: rtl/oscan1_pkg.sv
// Shared types for the single-line deserializer.
// Assumes: slot codes are fixed because the checker and the bench decode them.
package oscan1_pkg;
    typedef enum logic [1:0] {
        SLOT_NTDI = 2'd0,
        SLOT_TMS  = 2'd1,
        SLOT_TDO  = 2'd2
    } slot_t;
endpackage

// File: rtl/oscan1_sync.sv
// Brings the test clock and the data line into the system domain and flags
// each rising edge of the test clock.
// Assumes: both pins pass through chains of equal depth, so the data value
// leaving its chain belongs to the same sampling instant as the edge.
module oscan1_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tckc_i,
    input  logic tmsc_i,
    output logic rise_o,
    output logic line_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] ck_q;
    logic [STAGES-1:0] ln_q;
    logic [STAGES:0]   ck_ext;
    logic [STAGES:0]   ln_ext;
    logic              ck_prev;

    assign ck_ext = {ck_q, tckc_i};
    assign ln_ext = {ln_q, tmsc_i};

    // Shift both pins through their synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ck_q    <= '0;
            ln_q    <= '0;
            ck_prev <= 1'b0;
        end else begin
            ck_q    <= ck_ext[STAGES-1:0];
            ln_q    <= ln_ext[STAGES-1:0];
            ck_prev <= ck_q[LAST];
        end
    end

    // A rising edge is a synchronized high after a synchronized low.
    assign rise_o = ck_q[LAST] & ~ck_prev;
    assign line_o = ln_q[LAST];
endmodule

// File: rtl/oscan1_slot.sv
// Slot sequencer: tracks which of the three frame slots the next edge fills.
// Assumes: the mode input is synchronous to clk. On entry the slot is set to
// TMS, on exit it is cleared at once, and entry takes priority over an edge.
module oscan1_slot
    import oscan1_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  mode_i,
    input  logic  rise_i,
    output slot_t slot_o,
    output logic  mode_q_o,
    output logic  entry_o
);
    slot_t slot_q;
    logic  mode_q;

    assign entry_o  = mode_i & ~mode_q;
    assign slot_o   = slot_q;
    assign mode_q_o = mode_q;

    // Register the mode so entry can be detected as a 0-to-1 change.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= mode_i;
    end

    // Move to the next slot on each edge; entry and exit override this.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_NTDI;
        end else if (!mode_i) begin
            slot_q <= SLOT_NTDI;
        end else if (entry_o) begin
            slot_q <= SLOT_TMS;
        end else if (rise_i) begin
            unique case (slot_q)
                SLOT_NTDI: slot_q <= SLOT_TMS;
                SLOT_TMS:  slot_q <= SLOT_TDO;
                default:   slot_q <= SLOT_NTDI;
            endcase
        end
    end
endmodule

// File: rtl/oscan1_capture.sv
// Holds the bits of the open frame and publishes the finished frame with a
// one-cycle strobe. In four-wire mode it passes the line through as TMS.
// Assumes: the slot and mode_q inputs come from the sequencer, and an edge in
// the entry cycle is dropped.
module oscan1_capture
    import oscan1_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rise_i,
    input  logic  line_i,
    input  logic  mode_q_i,
    input  logic  entry_i,
    input  slot_t slot_i,
    output logic  stb_o,
    output logic  tdi_o,
    output logic  tms_o,
    output logic  tdo_o,
    output logic  ok_o
);
    logic tdi_hold;
    logic tms_hold;

    // Fill the frame slots and publish on the final slot or in pass-through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tdi_hold <= 1'b0;
            tms_hold <= 1'b0;
            stb_o    <= 1'b0;
            tdi_o    <= 1'b0;
            tms_o    <= 1'b0;
            tdo_o    <= 1'b0;
            ok_o     <= 1'b0;
        end else begin
            stb_o <= 1'b0;
            if (entry_i) begin
                tdi_hold <= 1'b0;
            end else if (rise_i) begin
                if (mode_q_i) begin
                    unique case (slot_i)
                        SLOT_NTDI: tdi_hold <= ~line_i;
                        SLOT_TMS:  tms_hold <= line_i;
                        default: begin
                            stb_o <= 1'b1;
                            tdi_o <= tdi_hold;
                            tms_o <= tms_hold;
                            tdo_o <= line_i;
                            ok_o  <= 1'b1;
                        end
                    endcase
                end else begin
                    stb_o <= 1'b1;
                    tdi_o <= 1'b0;
                    tms_o <= line_i;
                    tdo_o <= 1'b0;
                    ok_o  <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/oscan1_deser.sv
// Top level: synchronizer, slot sequencer and frame capture.
// Assumes: tckc_i and tmsc_i are asynchronous, and scan_mode_i is synchronous to clk.
module oscan1_deser
    import oscan1_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tckc_i,
    input  logic tmsc_i,
    input  logic scan_mode_i,
    output logic jtag_stb_o,
    output logic tdi_o,
    output logic tms_o,
    output logic tdo_o,
    output logic bits_ok_o
);
    logic  rise_w;
    logic  line_w;
    logic  mode_q;
    logic  entry_w;
    slot_t slot_w;

    oscan1_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tckc_i (tckc_i),
        .tmsc_i (tmsc_i),
        .rise_o (rise_w),
        .line_o (line_w)
    );

    oscan1_slot slot_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (scan_mode_i),
        .rise_i   (rise_w),
        .slot_o   (slot_w),
        .mode_q_o (mode_q),
        .entry_o  (entry_w)
    );

    oscan1_capture cap_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_i   (rise_w),
        .line_i   (line_w),
        .mode_q_i (mode_q),
        .entry_i  (entry_w),
        .slot_i   (slot_w),
        .stb_o    (jtag_stb_o),
        .tdi_o    (tdi_o),
        .tms_o    (tms_o),
        .tdo_o    (tdo_o),
        .ok_o     (bits_ok_o)
    );
endmodule

// File: rtl/oscan1_deser_chk.sv
// Checker for the deserializer, attached to the top module by bind.
module oscan1_deser_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scan_mode_i,
    input logic       mode_q,
    input logic [1:0] slot,
    input logic       stb,
    input logic       ok,
    input logic       tdi,
    input logic       tdo
);
    // R3: a strobe never lasts two cycles
    p_single_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb);

    // R2: a pass-through strobe carries invalid TDI/TDO
    p_fourwire_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !$past(mode_q)) |-> (!ok && !tdi && !tdo));

    // R6: a valid frame is published only from the TDO slot
    p_frame_from_tdo_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && ok) |-> ($past(mode_q) && $past(slot) == 2'd2));

    // R7: entry sets the slot to TMS
    p_entry_tms_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_mode_i && !mode_q) |=> (slot == 2'd1));

    // R8: exit clears the slot
    p_exit_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_mode_i |=> (slot == 2'd0));

    // R9: the unused slot code is never reached
    p_slot_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        slot != 2'd3);
endmodule

bind oscan1_deser oscan1_deser_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_mode_i (scan_mode_i),
    .mode_q      (mode_q),
    .slot        (slot_w),
    .stb         (jtag_stb_o),
    .ok          (bits_ok_o),
    .tdi         (tdi_o),
    .tdo         (tdo_o)
);

// File: tb/oscan1_deser_tb_top.sv
`timescale 1ns/1ps
module oscan1_deser_tb_top;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tckc = 1'b0;
    logic tmsc = 1'b0;
    logic scan_mode = 1'b0;
    logic stb, tdi, tms, tdo, ok;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench-side frame model
    bit m_mode = 0;
    int m_slot = 0;
    bit m_tdi = 0;
    bit m_tms = 0;
    bit l_tdi = 0, l_tms = 0, l_tdo = 0, l_ok = 0;

    always #4 clk = ~clk;

    oscan1_deser #(.SYNC_STAGES(SYNC)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tckc_i      (tckc),
        .tmsc_i      (tmsc),
        .scan_mode_i (scan_mode),
        .jtag_stb_o  (stb),
        .tdi_o       (tdi),
        .tms_o       (tms),
        .tdo_o       (tdo),
        .bits_ok_o   (ok)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit inv(input bit b);
        return ~b;
    endfunction

    task automatic set_mode(input bit m);
        @(negedge clk);
        scan_mode = m;
        if (m && !m_mode) begin
            m_slot = 1;
            m_tdi  = 0;
        end
        if (!m) m_slot = 0;
        m_mode = m;
        repeat (2) @(negedge clk);
    endtask

    // One test-clock cycle carrying line value v, checked against the model.
    task automatic tck_bit(input bit v);
        int hits = 0;
        int at = 0;
        bit s_tdi = 0, s_tms = 0, s_tdo = 0, s_ok = 0;
        @(negedge clk);
        tmsc = v;
        repeat (2) @(negedge clk);
        tckc = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (stb) begin
                hits++;
                if (at == 0) begin
                    at = i;
                    s_tdi = tdi; s_tms = tms; s_tdo = tdo; s_ok = ok;
                end
            end
        end
        tckc = 1'b0;
        repeat (3) @(negedge clk);
        if (!m_mode) begin
            chk("R2 strobe count", hits, 1);
            chk("R3 latency", at, SYNC + 1);
            chk("R2 tms", s_tms, v);
            chk("R2 tdi", s_tdi, 0);
            chk("R2 tdo", s_tdo, 0);
            chk("R2 valid", s_ok, 0);
            l_tdi = s_tdi; l_tms = s_tms; l_tdo = s_tdo; l_ok = s_ok;
        end else if (m_slot == 0 || m_slot == 1) begin
            if (m_slot == 0) m_tdi = inv(v);
            else             m_tms = v;
            chk("R6 silent edge", hits, 0);
            chk("R6 tdi held", tdi, l_tdi);
            chk("R6 tms held", tms, l_tms);
            chk("R6 tdo held", tdo, l_tdo);
            chk("R6 valid held", ok, l_ok);
            m_slot++;
        end else begin
            chk("R6 strobe count", hits, 1);
            chk("R3 latency", at, SYNC + 1);
            chk("R4 tdi", s_tdi, m_tdi);
            chk("R5 tms", s_tms, m_tms);
            chk("R6 tdo", s_tdo, v);
            chk("R6 valid", s_ok, 1);
            l_tdi = s_tdi; l_tms = s_tms; l_tdo = s_tdo; l_ok = s_ok;
            m_slot = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h1C7A);
        repeat (4) @(negedge clk);
        chk("R1 strobe in reset", stb, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 strobe", stb, 0);
        chk("R1 tdi", tdi, 0);
        chk("R1 tms", tms, 0);
        chk("R1 tdo", tdo, 0);
        chk("R1 valid", ok, 0);

        // four-wire pass-through
        tck_bit(1); tck_bit(0); tck_bit(1);
        // entry: first frame is TMS, TDO with TDI reported 0 (R7)
        set_mode(1);
        tck_bit(1); tck_bit(0);
        chk("R7 first frame tdi", l_tdi, 0);
        // full frame with line 0 in slot 0 -> TDI 1 (R4)
        tck_bit(0); tck_bit(0); tck_bit(1);
        chk("R4 inverted tdi", l_tdi, 1);
        // partial frame then exit (R8)
        tck_bit(0);
        set_mode(0);
        tck_bit(0);
        chk("R8 pass-through after exit", l_ok, 0);
        set_mode(1);
        tck_bit(1); tck_bit(1);
        chk("R8 re-entry at TMS slot", l_ok, 1);

        // random mix with mode toggles at arbitrary slots
        for (int n = 0; n < 500; n++) begin
            if (($urandom % 16) == 0) set_mode(!m_mode);
            tck_bit(1'($urandom % 2));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule